// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block drives the outbound side of a serial audio codec link. Its clock is the serial bit clock that the codec supplies. From that clock it derives the frame-synchronisation output and it shifts one frame per 256 bit clocks onto the serial data line. Each frame carries a 16-bit tag followed by twelve 20-bit slots.

Each frame is taken from a parallel buffer made up of one tag word and twelve slot words. The buffer is loaded once per frame through a valid/acknowledge pair. If the producer has no frame ready when the block takes one, an all-zero frame is sent, so the tag carries no valid marks. A shut-off input forces both link outputs low. When it is released, framing starts again from a defined point.

Outputs change on the rising clock edge, so the far end can sample them on the falling edge. The sync pulse rises one bit clock ahead of the first tag bit.

Top module: `audio_link_tx`

## Requirements
- R1: Sync rises once every 256 clocks, so a frame lasts 256 clocks. The internal position counter wraps from its last value back to zero.
- R2: In each frame, sync_o stays high for 16 consecutive clocks and low for the other 240.
- R3: The clock after sync_o rises carries tag_i[15]. The next 15 clocks carry tag_i[14] down to tag_i[0].
- R4: The twelve slots follow the tag, each sent most significant bit first. Slot k is taken from slot_data_i[20k+19:20k], and slot 0 goes first.
- R5: frm_ack_o is high for exactly one clock per frame. That clock is the one just before sync_o rises. The buffer is sampled at the rising edge that ends that clock, and only if frm_valid_i is high at that edge.
- R6: If frm_valid_i is low at the taking edge, every bit of the next frame is 0, including the tag.
- R7: Starting at the first edge where shut_off_i is sampled high, sync_o and sdo_o are held low and frm_ack_o stays low for as long as shut_off_i stays high.
- R8: While rst_ni is low, sync_o, sdo_o and frm_ack_o are all low.
- R9: After reset or shut-off is released, frm_ack_o goes high after the first rising edge. sync_o rises at the second rising edge, and tag bit 15 appears at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock from the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shut_off_i | input | 1 | Parks the link outputs low |
| frm_valid_i | input | 1 | Frame buffer holds a new frame |
| tag_i | input | 16 | Tag word of the frame buffer |
| slot_data_i | input | 240 | Twelve 20-bit slot words, slot 0 in the low bits |
| frm_ack_o | output | 1 | Frame take strobe, one clock before the frame starts |
| sync_o | output | 1 | Frame synchronisation output |
| sdo_o | output | 1 | Serial data output |

## Verification
The hardest case to reach from the ports is shut-off landing in the middle of a frame that has already been taken, and then releasing it. The link has to fall silent at once, drop the interrupted frame, and come back with a new frame on the exact restart timing. The bench asserts shut-off at an arbitrary point after a run of random frames. It checks the quiet outputs for twenty clocks, then releases shut-off and times the ack and the sync rise edge by edge before normal frame checking resumes. Frames with no valid buffer are mixed at random into the runs to reach the all-zero case.

// File: rtl/audio_link_pkg.sv
package audio_link_pkg;
  localparam int unsigned TAG_W_DEF     = 16;
  localparam int unsigned SLOT_W_DEF    = 20;
  localparam int unsigned NUM_SLOTS_DEF = 12;
  localparam int unsigned SYNC_LEN_DEF  = 16;

  function automatic int unsigned frame_len(int unsigned tw, int unsigned sw, int unsigned ns);
    return tw + sw * ns;
  endfunction
endpackage

// File: rtl/audio_link_timer.sv
module audio_link_timer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SYNC_LEN  = 16,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shut_off_i,
  output logic [CNT_W-1:0] nxt_pos_o,
  output logic             sync_nxt_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LOAD_POS = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] RESTART  = CNT_W'(FRAME_LEN - 3);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(SYNC_LEN - 1);

  logic [CNT_W-1:0] pos_q;

  always_comb begin
    nxt_pos_o  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    // sync leads the first tag bit by one clock
    sync_nxt_o = (nxt_pos_o == LAST_POS) || (nxt_pos_o < TAG_END);
    load_o     = (pos_q == LOAD_POS) && !shut_off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pos_q <= RESTART;
    else if (shut_off_i) pos_q <= RESTART;
    else                 pos_q <= nxt_pos_o;
  end
endmodule

// File: rtl/audio_link_store.sv
module audio_link_store #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned FRAME_LEN = TAG_W + SLOT_W * NUM_SLOTS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        valid_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data_i,
  output logic [FRAME_LEN-1:0]        frame_o
);
  logic [FRAME_LEN-1:0] packed_w;

  assign packed_w[FRAME_LEN-1 -: TAG_W] = tag_i;

  // slot 0 sits just below the tag so it is sent first
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign packed_w[(NUM_SLOTS-1-k)*SLOT_W +: SLOT_W] = slot_data_i[k*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_o <= '0;
    else if (load_i) frame_o <= valid_i ? packed_w : '0;
  end
endmodule

// File: rtl/audio_link_drive.sv
module audio_link_drive #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shut_off_i,
  input  logic [CNT_W-1:0]     nxt_pos_i,
  input  logic                 sync_nxt_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic                 sync_o,
  output logic                 sdo_o
);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] bit_idx;
  assign bit_idx = TOP_IDX - nxt_pos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else if (shut_off_i) begin
      sync_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else begin
      sync_o <= sync_nxt_i;
      sdo_o  <= frame_i[bit_idx];
    end
  end
endmodule

// File: rtl/audio_link_tx.sv
module audio_link_tx #(
  parameter int unsigned TAG_W     = audio_link_pkg::TAG_W_DEF,
  parameter int unsigned SLOT_W    = audio_link_pkg::SLOT_W_DEF,
  parameter int unsigned NUM_SLOTS = audio_link_pkg::NUM_SLOTS_DEF,
  parameter int unsigned SYNC_LEN  = audio_link_pkg::SYNC_LEN_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        shut_off_i,
  input  logic                        frm_valid_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data_i,
  output logic                        frm_ack_o,
  output logic                        sync_o,
  output logic                        sdo_o
);
  localparam int unsigned FRAME_LEN = audio_link_pkg::frame_len(TAG_W, SLOT_W, NUM_SLOTS);
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]     nxt_pos;
  logic                 sync_nxt;
  logic                 load;
  logic [FRAME_LEN-1:0] frame_q;

  audio_link_timer #(.FRAME_LEN(FRAME_LEN), .SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shut_off_i (shut_off_i),
    .nxt_pos_o  (nxt_pos),
    .sync_nxt_o (sync_nxt),
    .load_o     (load)
  );

  audio_link_store #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
                     .FRAME_LEN(FRAME_LEN)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .valid_i     (frm_valid_i),
    .tag_i       (tag_i),
    .slot_data_i (slot_data_i),
    .frame_o     (frame_q)
  );

  audio_link_drive #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shut_off_i (shut_off_i),
    .nxt_pos_i  (nxt_pos),
    .sync_nxt_i (sync_nxt),
    .frame_i    (frame_q),
    .sync_o     (sync_o),
    .sdo_o      (sdo_o)
  );

  assign frm_ack_o = load;
endmodule

// File: rtl/audio_link_tx_chk.sv
module audio_link_tx_chk #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SYNC_LEN  = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic shut_off_i,
  input logic frm_ack_o,
  input logic sync_o,
  input logic sdo_o
);
  localparam int unsigned W = $clog2(FRAME_LEN) + 1;
  localparam logic [W-1:0] SAT    = {W{1'b1}};
  localparam logic [W-1:0] PERIOD = W'(FRAME_LEN);
  localparam logic [W-1:0] HI_LEN = W'(SYNC_LEN);

  logic         sync_d, dirty, have_prev;
  logic [W-1:0] hi_len, per_len;
  logic         rise;

  assign rise = sync_o && !sync_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d    <= 1'b0;
      dirty     <= 1'b0;
      have_prev <= 1'b0;
      hi_len    <= '0;
      per_len   <= '0;
    end else begin
      sync_d  <= sync_o;
      hi_len  <= !sync_o ? '0 : (hi_len == SAT) ? hi_len : hi_len + 1'b1;
      per_len <= rise ? W'(1) : (per_len == SAT) ? per_len : per_len + 1'b1;
      if (shut_off_i) begin
        dirty     <= 1'b1;
        have_prev <= 1'b0;
      end else if (rise) begin
        dirty     <= 1'b0;
        have_prev <= 1'b1;
      end
    end
  end

  assert_frame_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && have_prev && !dirty && !shut_off_i |-> per_len == PERIOD);

  assert_sync_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o && sync_d && !dirty && !shut_off_i |-> hi_len == HI_LEN);

  assert_ack_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_ack_o |=> !frm_ack_o);

  assert_ack_leads_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_ack_o |-> !sync_o ##1 sync_o);

  assert_shut_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shut_off_i) |-> !sync_o && !sdo_o);

  assert_shut_no_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_off_i |-> !frm_ack_o);
endmodule

bind audio_link_tx audio_link_tx_chk #(.FRAME_LEN(FRAME_LEN), .SYNC_LEN(SYNC_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shut_off_i (shut_off_i),
  .frm_ack_o  (frm_ack_o),
  .sync_o     (sync_o),
  .sdo_o      (sdo_o)
);

// File: tb/audio_link_tx_bench.sv
`timescale 1ns/1ps
module audio_link_tx_bench;
  localparam int TAG_W = 16, SLOT_W = 20, NUM_SLOTS = 12, SYNC_LEN = 16;
  localparam int FL = TAG_W + SLOT_W * NUM_SLOTS;

  logic clk = 1'b0, rst_n = 1'b0, shut = 1'b0, valid = 1'b0;
  logic [TAG_W-1:0] tag = '0;
  logic [NUM_SLOTS*SLOT_W-1:0] slots = '0;
  logic ack, sync, sdo;

  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  audio_link_tx u_audio_link_tx (
    .clk_i(clk), .rst_ni(rst_n), .shut_off_i(shut), .frm_valid_i(valid),
    .tag_i(tag), .slot_data_i(slots), .frm_ack_o(ack), .sync_o(sync), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // frame as sent, first bit at the top (R3, R4)
  function automatic logic [FL-1:0] build(input logic [TAG_W-1:0] t,
                                          input logic [NUM_SLOTS*SLOT_W-1:0] s);
    logic [FL-1:0] f;
    f[FL-1 -: TAG_W] = t;
    for (int k = 0; k < NUM_SLOTS; k++)
      f[(NUM_SLOTS-1-k)*SLOT_W +: SLOT_W] = s[k*SLOT_W +: SLOT_W];
    return f;
  endfunction

  logic [FL-1:0] exp_q[$];
  bit            empty_q[$];
  logic [FL-1:0] cur;
  bit            cur_empty, cap = 0;
  logic          psync = 1'b0;
  int            j = 0, bad_tag = 0, bad_slot = 0, bad_sync = 0;

  always @(negedge clk) begin
    if (!rst_n || shut) begin
      cap = 0; psync = 1'b0;
      exp_q.delete(); empty_q.delete();
    end else begin
      if (ack) begin
        exp_q.push_back(valid ? build(tag, slots) : '0);
        empty_q.push_back(!valid);
      end
      if (cap) begin
        j++;
        if (j <= FL && sdo !== cur[FL-j]) begin
          if (j <= TAG_W) bad_tag++; else bad_slot++;
        end
        if (j < FL && sync !== (j < SYNC_LEN)) bad_sync++;
        if (ack) chk(j == FL-1, "R5 ack position", j, FL-1);
        if (j == FL) begin
          chk(bad_tag == 0, "R3 tag bits", bad_tag, 0);
          chk(bad_slot == 0, cur_empty ? "R6 empty frame bits" : "R4 slot bits", bad_slot, 0);
          chk(bad_sync == 0, "R2 sync shape", bad_sync, 0);
        end
      end
      if (sync && !psync) begin
        if (cap) chk(j == FL, "R1 frame period", j, FL);
        if (exp_q.size() == 0) begin
          chk(0, "R5 sync without take", 0, 1);
          cap = 0;
        end else begin
          cur = exp_q.pop_front(); cur_empty = empty_q.pop_front();
          cap = 1; j = 0; bad_tag = 0; bad_slot = 0; bad_sync = 0;
        end
      end
      psync = sync;
    end
  end

  task automatic rand_inputs(input int pct);
    valid = ($urandom_range(99) < pct);
    tag   = TAG_W'($urandom);
    for (int k = 0; k < NUM_SLOTS; k++) slots[k*SLOT_W +: SLOT_W] = SLOT_W'($urandom);
  endtask

  task automatic feed(input int n, input int pct);
    repeat (n) begin
      @(negedge clk iff ack);
      @(posedge clk); #1;
      rand_inputs(pct);
    end
  endtask

  task automatic restart_check(input string tagname);
    @(posedge clk); @(negedge clk);
    chk(ack === 1'b1, {"R9 ack after first edge ", tagname}, ack, 1);
    chk(sync === 1'b0, {"R9 sync low before second edge ", tagname}, sync, 0);
    @(negedge clk);
    chk(sync === 1'b1, {"R9 sync at second edge ", tagname}, sync, 1);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sync === 1'b0 && sdo === 1'b0, "R8 outputs in reset", {sync, sdo}, 0);
    chk(ack === 1'b0, "R8 ack in reset", ack, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    valid = 1'b1; tag = '1; slots = '1;
    restart_check("reset");
    valid = 1'b1; tag = 16'hA5C3;
    for (int k = 0; k < NUM_SLOTS; k++)
      slots[k*SLOT_W +: SLOT_W] = (k % 2 == 0) ? 20'hAAAAA : 20'h0F0F1 + SLOT_W'(k);
    feed(1, 100);
    valid = 1'b0; tag = 16'hFFFF; slots = '1;
    feed(1, 100);
    feed(8, 100);
    feed(12, 50);
    repeat (100 + $urandom_range(60)) @(posedge clk);
    #1 shut = 1'b1;
    @(posedge clk);
    repeat (20) begin
      @(negedge clk);
      chk(sync === 1'b0 && sdo === 1'b0 && ack === 1'b0, "R7 quiet in shut-off",
          {sync, sdo, ack}, 0);
    end
    @(posedge clk); #1;
    shut = 1'b0;
    rand_inputs(100);
    restart_check("shut-off");
    feed(6, 70);
    repeat (FL + 8) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule